// File: doc/BRIEF.md
# Debounced Underload Status Monitor

This block watches four output stages (high-side 1, low-side 1, high-side 2, low-side 2) for underload. Each stage reports whether it is switched on and whether its load-current comparator says the current is below the undercurrent threshold. A per-stage counter qualifies the low-current condition. The condition must hold without a break, with the stage on, for a programmable number of clock cycles. Only then does the block latch a sticky flag for that stage.

The four sticky flags are read through a 16-bit status word on a simple single-cycle read port. Reading that word at its address clears the flags. The data returned is the value held before the clear. A global underload output is the OR of the sticky flags whose per-stage mask bit is low, so a masked stage still records its own flag but never raises the global output.

Top module: `uld_status_monitor`

## Requirements
- R1: The status word is decoded at read address 0x11. Stage 0 (high-side 1) appears at bit 9, stage 1 (low-side 1) at bit 8, stage 2 (high-side 2) at bit 7 and stage 3 (low-side 2) at bit 6. All other bits read 0. A read at any other address returns 0 and clears nothing, and `rd_data` is 0 whenever `rd_en` is low.
- R2: A stage whose `stage_on` bit is low never sets its flag, whatever its comparator shows. Leaving on-mode restarts its qualification count.
- R3: A stage's flag is set at the FILT_CYCLES-th consecutive rising edge at which both `stage_on` and `below_thr` are high (default 16). A run one edge shorter sets nothing, and a single low comparator edge restarts the count.
- R4: A set flag stays at 1 until a read-clear. If the qualified condition still persists after a clear, the flag sets again at the next edge.
- R5: A read at address 0x11 returns the flags as they were before that cycle's edge, and the flags are cleared at that edge.
- R6: When a stage qualifies at the same edge as a read-clear, the flag is 1 after the edge.
- R7: `uld_global` is the OR of all sticky flags whose `no_uld_mask` bit (bit i for stage i) is 0. It follows the mask combinationally and falls once the unmasked flags are cleared.
- R8: After a synchronous reset (`rst_n` low at a rising edge) all flags, counters and `uld_global` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_on | input | 4 | On-mode indication per stage |
| below_thr | input | 4 | Comparator: load current below threshold, per stage |
| no_uld_mask | input | 4 | Per-stage mask keeping the stage off the global flag |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Read data (combinational, pre-clear value) |
| uld_global | output | 1 | Global underload flag |

## Verification
Two functions can fall in the same cycle: a stage's qualification reaching its limit and a read-clear of the status word. The bench provokes this by holding a stage in low-current on-mode until the count is about to complete, and issuing the read exactly at that edge. It also reads while the condition persists after saturation. It judges the outcome against a behavioural reference model every cycle. The read must show the pre-clear value, and the flag must read 1 afterwards, never dropping to 0 in between.

// File: rtl/uld_pkg.sv
// Package: shared constants for the underload status monitor.
// Assumes four stages in the fixed order HS1, LS1, HS2, LS2.
package uld_pkg;
    localparam int NUM_STAGES  = 4;
    localparam int REG_W       = 16;
    localparam int ADDR_W      = 8;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h11;
    // Bit of stage 0; stage i lands at TOP_BIT - i.
    localparam int TOP_BIT     = 9;

    // Register bit position for a stage index.
    function automatic int stage_bit(input int idx);
        return TOP_BIT - idx;
    endfunction
endpackage

// File: rtl/uld_filter.sv
// Module: per-stage qualification counter.
// Counts consecutive edges with stage on and current below threshold;
// pulses qual on every edge once FILT_CYCLES edges have been seen.
// Assumes FILT_CYCLES >= 1.
module uld_filter #(
    parameter int FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stage_on,
    input  logic below,
    output logic qual
);
    localparam int CNT_W = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

    logic             cond;
    logic [CNT_W-1:0] cnt;

    // Condition under evaluation: only in on-mode.
    assign cond = stage_on & below;
    // Qualify when this edge completes the run.
    assign qual = cond & (cnt == CNT_LAST);

    // Count consecutive qualifying edges, saturating at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (!cond)     cnt <= '0;
        else if (cnt != CNT_LAST) cnt <= cnt + 1'b1;
    end

    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !below |=> (cnt == '0));
    assert_off_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_on |=> (cnt == '0) && !qual);
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);
endmodule

// File: rtl/uld_sticky.sv
// Module: one sticky status flag with clear-on-read.
// A set request wins over a clear in the same cycle.
module uld_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    // Hold, clear on read, set on qualification (set has priority).
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (set_i)  flag <= 1'b1;
        else if (clr_i)  flag <= 1'b0;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_i) |=> flag);
endmodule

// File: rtl/uld_status_monitor.sv
// Module: top of the underload status monitor.
// One filter and one sticky flag per stage; the status word is read
// combinationally and cleared at the edge of a read at its address.
// Assumes the read strobe is a single-cycle pulse per access.
module uld_status_monitor #(
    parameter int FILT_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  stage_on,
    input  logic [3:0]  below_thr,
    input  logic [3:0]  no_uld_mask,
    input  logic        rd_en,
    input  logic [7:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        uld_global
);
    import uld_pkg::*;

    logic [NUM_STAGES-1:0] qual;
    logic [NUM_STAGES-1:0] flags;
    logic                  rd_hit;
    logic [REG_W-1:0]      status_word;

    // Read decode for the status address.
    assign rd_hit = rd_en && (rd_addr == STATUS_ADDR);

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        uld_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .stage_on (stage_on[g]),
            .below    (below_thr[g]),
            .qual     (qual[g])
        );
        uld_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (qual[g]),
            .clr_i (rd_hit),
            .flag  (flags[g])
        );
    end

    // Place each stage flag at its register bit.
    always_comb begin
        status_word = '0;
        for (int i = 0; i < NUM_STAGES; i++)
            status_word[stage_bit(i)] = flags[i];
    end

    // Read data path: pre-clear value on a hit, zero otherwise.
    assign rd_data = rd_hit ? status_word : '0;

    // Global flag from unmasked stages.
    assign uld_global = |(flags & ~no_uld_mask);

    assert_global_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !(|qual)) |=> (flags == '0));
    assert_miss_no_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit) |=> ((flags & $past(flags)) == $past(flags)));
    assert_reset_R8: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));
endmodule

// File: tb/sim_uld_status_monitor.sv
module sim_uld_status_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] stage_on = '0, below_thr = '0, no_uld_mask = '0;
    logic rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic uld_global;

    int checks = 0, errors = 0;
    int mcnt [4];
    bit mflag [4];

    uld_status_monitor #(.FILT_CYCLES(FILT)) u0 (
        .clk(clk), .rst_n(rst_n), .stage_on(stage_on), .below_thr(below_thr),
        .no_uld_mask(no_uld_mask), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .uld_global(uld_global));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_word();
        logic [15:0] w = '0;
        for (int i = 0; i < 4; i++) w[9-i] = mflag[i];
        return w;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, compare outputs against model, step model at edge.
    task automatic step(input string tag, input logic [3:0] on, input logic [3:0] bl,
                        input logic [3:0] msk, input logic rd, input logic [7:0] ad);
        logic [15:0] exp_rd;
        logic exp_g;
        bit hit, cond, q;
        stage_on = on; below_thr = bl; no_uld_mask = msk; rd_en = rd; rd_addr = ad;
        #1;
        hit = rd && (ad == 8'h11);
        exp_rd = hit ? model_word() : 16'h0;
        exp_g = 1'b0;
        for (int i = 0; i < 4; i++) if (mflag[i] && !msk[i]) exp_g = 1'b1;
        check({tag, " rd_data"}, rd_data, exp_rd);
        check({tag, " global"}, {15'b0, uld_global}, {15'b0, exp_g});
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            cond = on[i] && bl[i];
            q = cond && (mcnt[i] == FILT-1);
            if (q) mflag[i] = 1'b1; else if (hit) mflag[i] = 1'b0;
            if (!cond) mcnt[i] = 0; else if (mcnt[i] < FILT-1) mcnt[i]++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin mcnt[i] = 0; mflag[i] = 0; end
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state visible through a read.
        step("R8 reset", 4'h0, 4'h0, 4'h0, 1'b1, 8'h11);
        // R2: below threshold while off never sets.
        repeat (FILT + 4) step("R2 off", 4'h0, 4'hF, 4'h0, 1'b0, 8'h0);
        step("R2 readback", 4'h0, 4'h0, 4'h0, 1'b1, 8'h11);
        // R3: run one short, then a dropout, then full run on stage 0.
        repeat (FILT - 1) step("R3 short", 4'h1, 4'h1, 4'h0, 1'b0, 8'h0);
        step("R3 drop", 4'h1, 4'h0, 4'h0, 1'b1, 8'h11);
        repeat (FILT - 1) step("R3 short2", 4'h1, 4'h1, 4'h0, 1'b0, 8'h0);
        step("R2 leave", 4'h0, 4'h1, 4'h0, 1'b1, 8'h11);
        repeat (FILT) step("R3 full", 4'h1, 4'h1, 4'h0, 1'b0, 8'h0);
        // R1: wrong address reads 0 and does not clear.
        step("R1 miss", 4'h0, 4'h0, 4'h0, 1'b1, 8'h12);
        step("R4 hold", 4'h0, 4'h0, 4'h0, 1'b0, 8'h11);
        // R7: mask stage 0 hides it from global.
        step("R7 mask", 4'h0, 4'h0, 4'h1, 1'b0, 8'h0);
        // R5: read returns pre-clear value, then cleared.
        step("R5 read", 4'h0, 4'h0, 4'h0, 1'b1, 8'h11);
        step("R5 after", 4'h0, 4'h0, 4'h0, 1'b1, 8'h11);
        // R6: qualification coincides with read-clear on stage 3.
        repeat (FILT - 1) step("R6 build", 4'h8, 4'h8, 4'h0, 1'b0, 8'h0);
        step("R6 same", 4'h8, 4'h8, 4'h0, 1'b1, 8'h11);
        step("R6 after", 4'h8, 4'h8, 4'h0, 1'b1, 8'h11);
        // R4: persistent condition re-sets after clear.
        step("R4 reset", 4'h0, 4'h0, 4'h0, 1'b1, 8'h11);
        // Mixed pattern on all stages with random reads and masks.
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] on, bl, m;
            logic rd;
            on = 4'($urandom);
            on = on | 4'($urandom);
            bl = 4'($urandom) | 4'($urandom) | 4'($urandom);
            m  = 4'($urandom);
            rd = ($urandom % 23) == 0;
            step("R7 mixed", on, bl, m, rd, ($urandom % 4 == 0) ? 8'h10 : 8'h11);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule